// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs read and write transfers on an external bus where one set of pins carries first the address and then the data. An address strobe (active low) marks the moment the address is valid. A data strobe (active low) frames the data window. The sequencer is clocked at twice the processor clock. Each of its clock periods is one *phase*, which is half a processor clock. This lets every strobe edge sit on a half-clock boundary.

A requester presents address, write data, direction and a byte flag, and holds `reqValid` high until `done` pulses. The data window is stretched by a programmable wait count (`waitCfg`) and by an external wait input. After a read, an optional idle state can be added. An external agent may ask for the bus with `holdReq`. The request is granted only between transfers. While it is granted, the bus and the strobe drivers are released.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, both strobes are high with their drivers on (`strbOe`=1), `busOe`=0, `holdAck`=0 and `done`=0.
- R2: A transfer drives the address for one phase with the address strobe high. It keeps driving the address for one more phase with the address strobe low. The data strobe falls one phase after the address strobe falls. On a read, `busOe` is 0 from that point.
- R3: The data strobe stays low for 2*(1+n) consecutive phases, where n is `waitCfg` plus the number of external wait extensions.
- R4: `waitIn` is sampled in the last phase of each data window. When `waitCfg`≥1, a high sample adds 2 phases and the input is sampled again in the new last phase. When `waitCfg`=0, `waitIn` has no effect.
- R5: The address strobe rises one phase after the data strobe rises. `done` is high for exactly one phase, which is the phase in which the data strobe has just risen.
- R6: On a write, the bus carries the write data from the data strobe fall until two phases after the data strobe rises. If a new request is pending, its address is driven two phases after the data strobe rises.
- R7: With `idleEn`=1, the next address after a read appears four phases after the data strobe rises instead of two. Writes never get the idle state.
- R8: Read data is taken from `busIn` in the last data-strobe-low phase, so bus changes after the rising edge are ignored. With `reqByte`=1, `rdData` holds `busIn[7:0]` with the upper bits zero.
- R9: A byte write (`reqByte`=1) repeats the low byte of `reqWdata` on every byte lane of the bus.
- R10: A hold request is granted only at a transfer boundary. If it arrives during a transfer, `holdAck` rises two phases after the data strobe rises. While `holdAck` is 1: `strbOe`=0, `busOe`=0 and both strobes read high.
- R11: After `holdReq` goes low, `holdAck` stays 1 for one more phase and then drops. `busOe` is 0 in the phase where `holdAck` drops.
- R12: If a hold request and a transfer request are present at the same boundary, the hold is granted first. The transfer starts after the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the processor clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request, held until `done` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | Byte-sized transfer |
| reqAddr | input | BUS_W | Transfer address |
| reqWdata | input | BUS_W | Write data |
| waitCfg | input | WAIT_W | Programmable wait clocks |
| idleEn | input | 1 | Insert idle state after reads |
| waitIn | input | 1 | External wait request (active high) |
| holdReq | input | 1 | External bus hold request |
| astbN | output | 1 | Address strobe, active low |
| dstbN | output | 1 | Data strobe, active low |
| strbOe | output | 1 | Strobe driver enable |
| busOut | output | BUS_W | Multiplexed bus output value |
| busOe | output | 1 | Multiplexed bus driver enable |
| busIn | input | BUS_W | Multiplexed bus input value |
| holdAck | output | 1 | Hold acknowledge |
| rdData | output | BUS_W | Captured read data |
| done | output | 1 | One-phase transfer completion pulse |

## Verification
The checker assumes that `holdReq` and `waitIn` are synchronous to the phase clock. It also assumes that a requester keeps `reqValid` and its fields steady from the start of a transfer until `done`. The stimulus changes every input only on the falling clock edge. It drops `reqValid` in the phase where `done` is seen, unless a back-to-back transfer is wanted. Wait is driven as a function of the strobe-low phase count seen so far, which sets an exact number of extensions. Hold requests are raised and released only from those same falling-edge points.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ALAT,
    S_DATA,
    S_POST,
    S_RECOV,
    S_IDLST,
    S_HOLD,
    S_HREL
  } busState_t;

  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveData;
    logic capture;
  } dpCtl_t;

endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              idleEn,
  input  logic              waitIn,
  input  logic              holdReq,
  output dpCtl_t            ctl,
  output logic              astbN,
  output logic              dstbN,
  output logic              strbOe,
  output logic              holdAck,
  output logic              done
);
  // phase counter must hold 2*(1+max wait)-1
  localparam int CNT_W = WAIT_W + 2;

  busState_t         state, stateNx;
  logic [CNT_W-1:0]  cnt, cntNx;
  logic [WAIT_W-1:0] waitQ;
  logic              wrQ, idleQ;
  logic              capture;

  // decision taken whenever a transfer may start or the bus may be yielded
  function automatic busState_t atBoundary(input logic hold, input logic req);
    if (hold) return S_HOLD;
    if (req) return S_ADDR;
    return S_IDLE;
  endfunction

  always_comb begin
    stateNx = state;
    cntNx   = cnt;
    capture = 1'b0;
    case (state)
      S_IDLE:  stateNx = atBoundary(holdReq, reqValid);
      S_ADDR:  stateNx = S_ALAT;
      S_ALAT: begin
        stateNx = S_DATA;
        cntNx   = {1'b0, waitQ, 1'b1};
      end
      S_DATA: begin
        if (cnt == '0) begin
          if ((waitQ != '0) && waitIn) begin
            cntNx = CNT_W'(1);
          end else begin
            stateNx = S_POST;
            capture = 1'b1;
          end
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      S_POST:  stateNx = S_RECOV;
      S_RECOV: begin
        if (!wrQ && idleQ) begin
          stateNx = S_IDLST;
          cntNx   = CNT_W'(1);
        end else begin
          stateNx = atBoundary(holdReq, reqValid);
        end
      end
      S_IDLST: begin
        if (cnt == '0) stateNx = atBoundary(holdReq, reqValid);
        else cntNx = cnt - 1'b1;
      end
      S_HOLD:  if (!holdReq) stateNx = S_HREL;
      S_HREL:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      waitQ <= '0;
      wrQ   <= 1'b0;
      idleQ <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      if (stateNx == S_ADDR) begin
        waitQ <= waitCfg;
        wrQ   <= reqWrite;
        idleQ <= idleEn;
      end
    end
  end

  always_comb begin
    ctl.loadReq   = (stateNx == S_ADDR);
    ctl.driveAddr = (state == S_ADDR) || (state == S_ALAT);
    ctl.driveData = wrQ && ((state == S_DATA) || (state == S_POST) || (state == S_RECOV));
    ctl.capture   = capture;
  end

  assign astbN   = !((state == S_ALAT) || (state == S_DATA) || (state == S_POST));
  assign dstbN   = (state != S_DATA);
  assign holdAck = (state == S_HOLD) || (state == S_HREL);
  assign strbOe  = !holdAck;
  assign done    = (state == S_POST);

endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqByte,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic [BUS_W-1:0] rdData
);
  localparam int LANES = BUS_W / 8;
  localparam int PAD_W = BUS_W - 8;

  logic [BUS_W-1:0] addrQ, wdataQ, laneRep, wrFmt, rdFmt, rdQ;
  logic             byteQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneRep[g*8 +: 8] = wdataQ[7:0];
  end

  if (PAD_W > 0) begin : g_pad
    assign rdFmt = byteQ ? {{PAD_W{1'b0}}, busIn[7:0]} : busIn;
  end else begin : g_nopad
    assign rdFmt = busIn;
  end

  assign wrFmt = byteQ ? laneRep : wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      byteQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        byteQ  <= reqByte;
      end
      if (ctl.capture) rdQ <= rdFmt;
    end
  end

  always_comb begin
    if (ctl.driveAddr) busOut = addrQ;
    else if (ctl.driveData) busOut = wrFmt;
    else busOut = '0;
  end

  assign busOe  = ctl.driveAddr || ctl.driveData;
  assign rdData = rdQ;

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import mbs_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              idleEn,
  input  logic              waitIn,
  input  logic              holdReq,
  output logic              astbN,
  output logic              dstbN,
  output logic              strbOe,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  input  logic [BUS_W-1:0]  busIn,
  output logic              holdAck,
  output logic [BUS_W-1:0]  rdData,
  output logic              done
);
  dpCtl_t ctl;

  mbs_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .waitCfg(waitCfg), .idleEn(idleEn), .waitIn(waitIn), .holdReq(holdReq),
    .ctl(ctl), .astbN(astbN), .dstbN(dstbN), .strbOe(strbOe),
    .holdAck(holdAck), .done(done)
  );

  mbs_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqByte(reqByte), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rdData(rdData)
  );

endmodule

// File: rtl/mux_bus_sequencer_chk.sv
module mux_bus_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic astbN,
  input logic dstbN,
  input logic strbOe,
  input logic busOe,
  input logic holdAck,
  input logic holdReq,
  input logic done
);
  // data strobe only ever low inside an address strobe low window
  p_dstb_in_astb_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dstbN |-> !astbN);

  // data strobe falls one phase after the address strobe, address still driven
  p_dstb_after_astb_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dstbN) |-> ($past(!astbN) && $past(busOe)));

  p_astb_after_dstb_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dstbN) |=> $rose(astbN));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!strbOe && !busOe && astbN && dstbN));

  p_hold_boundary_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(astbN) && $past(dstbN)));

  p_hold_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq && $past(!holdReq)) |=> !holdAck);

  p_quiet_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdAck) |-> !busOe);

endmodule

bind mux_bus_sequencer mux_bus_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .astbN(astbN), .dstbN(dstbN), .strbOe(strbOe),
  .busOe(busOe), .holdAck(holdAck), .holdReq(holdReq), .done(done)
);

// File: tb/mux_bus_sequencer_test.sv
module mux_bus_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 16;
  localparam int WAIT_W = 2;
  localparam int MAXPH = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqByte = 1'b0;
  logic [BUS_W-1:0] reqAddr = '0, reqWdata = '0, busIn = '0;
  logic [WAIT_W-1:0] waitCfg = '0;
  logic idleEn = 1'b0, waitIn = 1'b0, holdReq = 1'b0;
  logic astbN, dstbN, strbOe, busOe, holdAck, done;
  logic [BUS_W-1:0] busOut, rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_sequencer #(.BUS_W(BUS_W), .WAIT_W(WAIT_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqByte(reqByte), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .waitCfg(waitCfg), .idleEn(idleEn), .waitIn(waitIn), .holdReq(holdReq),
    .astbN(astbN), .dstbN(dstbN), .strbOe(strbOe), .busOut(busOut),
    .busOe(busOe), .busIn(busIn), .holdAck(holdAck), .rdData(rdData),
    .done(done)
  );

  int nTests = 0, nFails = 0;
  bit finished = 1'b0;

  bit aR [MAXPH], dR [MAXPH], oeR [MAXPH], doneR [MAXPH], ackR [MAXPH], sOeR [MAXPH];
  logic [BUS_W-1:0] busR [MAXPH];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expLow(input int w, input int extra);
    return 2 * (1 + w + ((w > 0) ? extra : 0));
  endfunction

  function automatic logic [BUS_W-1:0] expWr(input bit byt, input logic [BUS_W-1:0] wd);
    return byt ? {2{wd[7:0]}} : wd;
  endfunction

  function automatic logic [BUS_W-1:0] expRd(input bit byt, input logic [BUS_W-1:0] v);
    return byt ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic runCycle(input bit wr, input bit byt, input logic [BUS_W-1:0] addr,
                          input logic [BUS_W-1:0] wd, input logic [BUS_W-1:0] rdv,
                          input int w, input bit idl, input int extra,
                          input bit chain, input int holdAt);
    int lowCnt = 0, dones = 0, want, target, len, post, nx, ackFirst, doneCnt;
    bit okBus;
    want   = chain ? 2 : 1;
    target = 2 * (1 + w + extra);
    @(negedge clk);
    reqWrite = wr; reqByte = byt; reqAddr = addr; reqWdata = wd;
    waitCfg = WAIT_W'(w); idleEn = idl; waitIn = 1'b1; reqValid = 1'b1;
    for (int j = 0; j < MAXPH; j++) begin
      @(negedge clk);
      aR[j] = astbN; dR[j] = dstbN; oeR[j] = busOe; doneR[j] = done;
      ackR[j] = holdAck; sOeR[j] = strbOe; busR[j] = busOut;
      if (dstbN) begin
        lowCnt = 0; waitIn = 1'b1;
      end else begin
        lowCnt++; waitIn = (lowCnt < target);
      end
      busIn = !dstbN ? rdv : (~rdv ^ BUS_W'(j));
      if (done) begin
        dones++;
        if (dones == want) reqValid = 1'b0;
      end
      if (j == holdAt) holdReq = 1'b1;
    end
    len  = expLow(w, extra);
    post = 2 + len;
    check(aR[0] && oeR[0] && busR[0] == addr, "R2", "address phase before strobe", busR[0], addr);
    check(!aR[1] && dR[1] && oeR[1] && busR[1] == addr, "R2", "address held after strobe", busR[1], addr);
    check(!dR[2], "R2", "data strobe low one phase after address strobe", dR[2], 0);
    if (!wr) check(!oeR[2], "R2", "bus released on read", oeR[2], 0);
    lowCnt = 0;
    for (int j = 2; j < MAXPH && !dR[j]; j++) lowCnt++;
    check(lowCnt == len, (w == 0 && extra > 0) ? "R4" : "R3", "data strobe low phases", lowCnt, len);
    check(!aR[post] && aR[post+1], "R5", "address strobe rises after data strobe", aR[post+1], 1);
    doneCnt = 0;
    for (int j = 0; j <= post + 1; j++) if (doneR[j]) doneCnt++;
    check(doneR[post] && doneCnt == 1, "R5", "done single pulse", doneCnt, 1);
    if (wr) begin
      okBus = 1'b1;
      for (int j = 2; j <= post + 1; j++) if (!oeR[j] || busR[j] != expWr(byt, wd)) okBus = 1'b0;
      check(okBus, byt ? "R9" : "R6", "write data on bus", busR[post+1], expWr(byt, wd));
      if (!chain) check(!oeR[post+2], "R6", "bus released after write hold", oeR[post+2], 0);
    end else begin
      check(rdData == expRd(byt, rdv), "R8", "captured read data", rdData, expRd(byt, rdv));
    end
    if (chain) begin
      nx = -1;
      for (int j = MAXPH - 1; j > post + 1; j--) if (!aR[j]) nx = j;
      check(nx - 1 == post + ((!wr && idl) ? 4 : 2), (!wr && idl) ? "R7" : "R6",
            "next address phase after data strobe rise", nx - 1 - post, (!wr && idl) ? 4 : 2);
    end
    if (holdAt >= 0) begin
      ackFirst = -1;
      for (int j = MAXPH - 1; j >= 0; j--) if (ackR[j]) ackFirst = j;
      check(ackFirst == post + 2, "R10", "hold granted at boundary", ackFirst, post + 2);
      okBus = 1'b1;
      for (int j = 0; j < MAXPH; j++)
        if (ackR[j] && (sOeR[j] || oeR[j] || !aR[j] || !dR[j])) okBus = 1'b0;
      check(okBus, "R10", "drivers off during hold", okBus, 1);
    end
  endtask

  task automatic releaseHold();
    @(negedge clk);
    holdReq = 1'b0;
    @(negedge clk);
    check(holdAck == 1'b1, "R11", "ack held one phase", holdAck, 1);
    @(negedge clk);
    check(holdAck == 1'b0 && !busOe && strbOe, "R11", "ack released quietly", holdAck, 0);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFails++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7031);
    repeat (3) @(negedge clk);
    check(astbN && dstbN && strbOe && !busOe && !holdAck && !done, "R1", "state in reset",
          {astbN, dstbN, strbOe, busOe, holdAck, done}, 6'b111000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(astbN && dstbN && strbOe && !busOe && !holdAck && !done, "R1", "idle after reset",
          {astbN, dstbN, strbOe, busOe, holdAck, done}, 6'b111000);

    // directed: n = 0, 1, 3 with idle off and on, back to back reads
    runCycle(0, 0, 16'h1234, 16'h0, 16'hA5C3, 0, 0, 0, 1, -1);
    runCycle(0, 0, 16'h2345, 16'h0, 16'h5AC3, 1, 0, 0, 1, -1);
    runCycle(0, 0, 16'h3456, 16'h0, 16'h0FF0, 3, 0, 0, 1, -1);
    runCycle(0, 0, 16'h4567, 16'h0, 16'hF00F, 0, 1, 0, 1, -1);
    runCycle(0, 0, 16'h5678, 16'h0, 16'h1357, 1, 1, 0, 1, -1);
    runCycle(0, 0, 16'h6789, 16'h0, 16'h2468, 3, 1, 0, 1, -1);
    // external wait extensions and wait ignored at zero programmed waits (R4)
    runCycle(0, 0, 16'h789A, 16'h0, 16'hBEEF, 1, 0, 2, 0, -1);
    runCycle(1, 0, 16'h89AB, 16'hCAFE, 16'h0, 0, 0, 2, 0, -1);
    // writes: idle never applies (R7), byte write lane repeat (R9), byte read (R8)
    runCycle(1, 0, 16'h9ABC, 16'h1122, 16'h0, 2, 1, 0, 1, -1);
    runCycle(1, 1, 16'hABCD, 16'h33C4, 16'h0, 1, 0, 1, 0, -1);
    runCycle(0, 1, 16'hBCDE, 16'h0, 16'h77E1, 2, 0, 0, 0, -1);
    // hold requested in the middle of a cycle (R10, R11)
    runCycle(0, 0, 16'hCDEF, 16'h0, 16'h4321, 3, 0, 1, 0, 5);
    releaseHold();

    // R12: hold and request together at a boundary
    repeat (2) @(negedge clk);
    reqWrite = 1'b0; reqByte = 1'b0; reqAddr = 16'h0101; waitCfg = '0; idleEn = 1'b0;
    reqValid = 1'b1; holdReq = 1'b1;
    @(negedge clk);
    check(holdAck && astbN && !strbOe, "R12", "hold wins over request", holdAck, 1);
    repeat (3) @(negedge clk);
    check(holdAck && !done && !busOe, "R12", "request waits during hold", busOe, 0);
    releaseHold();
    begin
      int seen = 0;
      for (int j = 0; j < 20 && seen == 0; j++) begin
        @(negedge clk);
        if (done) begin
          seen = 1; reqValid = 1'b0;
        end
      end
      check(seen == 1, "R12", "deferred request completes", seen, 1);
    end
    repeat (3) @(negedge clk);

    // constrained random transfers
    for (int k = 0; k < 40; k++) begin
      bit wr, byt, idl, ch;
      int w, ex;
      wr  = 1'($urandom % 2);
      byt = 1'($urandom % 2);
      idl = 1'($urandom % 2);
      ch  = 1'($urandom % 2);
      w   = int'($urandom % 4);
      ex  = int'($urandom % 3);
      runCycle(wr, byt, 16'($urandom), 16'($urandom), 16'($urandom), w, idl, ex, ch, -1);
      repeat (2) @(negedge clk);
    end

    summary();
  end

endmodule